// File: doc/BRIEF.md
# Step-Adaptive Averaging Filter Stage

This block is the second filter stage behind a sinc-type decimator. Each first-stage sample arrives with a one-cycle valid strobe, together with the result of a long FIR path that is computed elsewhere and time-aligned with the sample. While the input is steady, the block forwards the FIR result. With fast mode enabled, it watches for large steps on the input. A step switches it to a short moving average, so the output follows the new level within a few samples. The averaging window then lengthens in stages as the input settles, and the block finally hands control back to the FIR path.

A bypass input routes raw first-stage samples straight to the output. When bypass and chop are both on, each output carries a pair tag so that a consumer can combine successive outputs of opposite chop polarity. A transient flag goes with every output and shows whether that output came from the averaging path.

The controller has six states. FIR_PASS forwards the FIR result. STEP_HOLD averages at the initial length while steps keep arriving. GROW2, GROW4, GROW8 and GROW16 average over 2, 4, 8 and 16 samples. The transitions are as follows:
- From any state, a detected step leads to STEP_HOLD.
- STEP_HOLD goes to GROW2 on the first sample without a step.
- GROW2 goes to GROW4 after its 2nd output, counting the output made on entry.
- GROW4 goes to GROW8 after 4 outputs.
- GROW8 goes to GROW16 after 8 outputs.
- GROW16 goes to FIR_PASS after 6 outputs.
- A sample taken with bypass on, or with fast mode off, returns the controller to FIR_PASS.

The controller advances only on valid samples.

Top module: `step_avg_filter`

## Requirements
- R1: `out_valid` is high exactly one clock after a cycle with `smp_valid` high, and low otherwise. Between outputs, `out_data`, `out_transient` and `out_pair_tag` hold their last values.
- R2: The step threshold is `full_scale/100` (integer division). It is registered one clock after `full_scale` changes. A step is declared when |sample − sample two valid samples earlier| is strictly greater than the threshold, and only once two valid samples have been seen since reset. With fast mode on and no step in FIR_PASS, the output is `fir_data`.
- R3: On a detected step with fast mode on, the output is the average over the initial length: 2 samples when `chop_en` is 1, or the current sample alone when `chop_en` is 0. The length stays there for as long as steps continue.
- R4: After the first step-free sample, the block produces 2 outputs averaged over 2 samples, then 4 over 4, then 8 over 8, then 6 over 16. The next step-free sample uses `fir_data`.
- R5: A step detected in any GROW state restarts at STEP_HOLD with the initial length.
- R6: `out_transient` is 1 on every averaged output and 0 on FIR and bypass outputs.
- R7: With `fast_en` 0 and bypass off, the output is `fir_data` and `out_transient` is 0.
- R8: With `skip_en` 1, the output is `smp_data` of that sample, whatever the state of `fast_en`.
- R9: With bypass and chop both on, `out_pair_tag` is 0 on the first such output after reset or after any other kind of sample, and then alternates 1, 0, 1… on each output. On all other outputs it is 0.
- R10: An average over N samples is the sum of the current sample and the N−1 previous valid samples, arithmetically shifted right by log2(N) (rounding toward minus infinity). Samples before reset count as 0. The history is updated on every valid sample in every mode.
- R11: During reset, `out_valid`, `out_data`, `out_transient` and `out_pair_tag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | First-stage sample strobe |
| smp_data | input | W | First-stage sample, signed |
| fir_data | input | W | Aligned FIR-path result, signed |
| fast_en | input | 1 | Enable step detection and averaging |
| skip_en | input | 1 | Bypass both paths |
| chop_en | input | 1 | Chop active |
| full_scale | input | W | Full-scale magnitude, unsigned |
| out_valid | output | 1 | Output strobe |
| out_data | output | W | Filtered sample, signed |
| out_transient | output | 1 | Output came from the averaging path |
| out_pair_tag | output | 1 | Chop-pair position in bypass mode |

## Verification
Every result is registered once: the output for a sample taken at clock edge n is due at edge n+1. The bench therefore drives inputs just after a falling edge and compares outputs at the next falling edge. A threshold change takes effect one edge after `full_scale` moves, so the bench leaves idle cycles after each change before it sends the next sample. The schedule, restart, threshold-boundary and pair-tag cases are each checked output by output against a bench model of the requirements.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
    localparam int AVG_DEPTH = 16;
    localparam int AVG_LVLS  = $clog2(AVG_DEPTH) + 1;
    localparam int LVL_W     = $clog2(AVG_LVLS);
    localparam int REP_W     = 4;

    typedef enum logic [2:0] {
        ST_FIR_PASS,
        ST_STEP_HOLD,
        ST_GROW2,
        ST_GROW4,
        ST_GROW8,
        ST_GROW16
    } sfa_state_e;

    typedef enum logic [1:0] {
        SRC_FIR,
        SRC_AVG,
        SRC_RAW
    } sfa_src_e;
endpackage

// File: rtl/sfa_history.sv
module sfa_history #(
    parameter int W = 24
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    push,
    input  logic signed [W-1:0]                     din,
    output logic [sfa_pkg::AVG_LVLS-1:0][W-1:0]     avg_o,
    output logic signed [W-1:0]                     prev2_o
);
    localparam int DEPTH = sfa_pkg::AVG_DEPTH;
    localparam int LVLS  = sfa_pkg::AVG_LVLS;
    localparam int SW    = W + $clog2(DEPTH);

    logic signed [W-1:0] hist_q [DEPTH-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH-1; k++) hist_q[k] <= '0;
        end else if (push) begin
            hist_q[0] <= din;
            for (int k = 1; k < DEPTH-1; k++) hist_q[k] <= hist_q[k-1];
        end
    end

    assign prev2_o = hist_q[1];

    for (genvar gi = 0; gi < LVLS; gi++) begin : g_lvl
        localparam int N = 1 << gi;
        logic signed [SW-1:0] acc;
        always_comb begin
            acc = SW'(din);
            for (int k = 0; k < N-1; k++) acc = acc + SW'(hist_q[k]);
        end
        assign avg_o[gi] = W'(acc >>> gi);
    end
endmodule

// File: rtl/sfa_step_det.sv
module sfa_step_det #(
    parameter int W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic signed [W-1:0] din,
    input  logic signed [W-1:0] prev2,
    input  logic [W-1:0]        full_scale,
    output logic                step
);
    logic [W-1:0]        fs_q;
    logic [W-1:0]        thr_q;
    logic [1:0]          fill_q;
    logic signed [W:0]   diff;
    logic [W:0]          mag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q   <= '0;
            thr_q  <= '0;
            fill_q <= '0;
        end else begin
            if (full_scale != fs_q) begin
                fs_q  <= full_scale;
                thr_q <= W'(full_scale / 100);
            end
            if (push && fill_q != 2'd2) fill_q <= fill_q + 2'd1;
        end
    end

    always_comb begin
        diff = (W+1)'(din) - (W+1)'(prev2);
        mag  = diff[W] ? (W+1)'(-diff) : diff;
        step = (fill_q == 2'd2) && (mag > {1'b0, thr_q});
    end
endmodule

// File: rtl/sfa_ctrl.sv
module sfa_ctrl (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic                        fast_en,
    input  logic                        skip_en,
    input  logic                        chop_en,
    input  logic                        step,
    output sfa_pkg::sfa_src_e           src,
    output logic [sfa_pkg::LVL_W-1:0]   len_idx,
    output sfa_pkg::sfa_state_e         state_o
);
    import sfa_pkg::*;

    localparam logic [REP_W-1:0] REP2  = REP_W'(2);
    localparam logic [REP_W-1:0] REP4  = REP_W'(4);
    localparam logic [REP_W-1:0] REP8  = REP_W'(8);
    localparam logic [REP_W-1:0] REP16 = REP_W'(6);

    sfa_state_e        state_q, state_d;
    logic [REP_W-1:0]  cnt_q, cnt_d;
    logic [LVL_W-1:0]  init_idx;

    assign init_idx = chop_en ? LVL_W'(1) : LVL_W'(0);
    assign state_o  = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FIR_PASS;
            cnt_q   <= '0;
        end else if (push) begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        src     = SRC_FIR;
        len_idx = '0;
        if (skip_en) begin
            src     = SRC_RAW;
            state_d = ST_FIR_PASS;
            cnt_d   = '0;
        end else if (!fast_en) begin
            state_d = ST_FIR_PASS;
            cnt_d   = '0;
        end else if (step) begin
            src     = SRC_AVG;
            len_idx = init_idx;
            state_d = ST_STEP_HOLD;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_FIR_PASS: begin
                    src = SRC_FIR;
                end
                ST_STEP_HOLD: begin
                    src     = SRC_AVG;
                    len_idx = LVL_W'(1);
                    state_d = ST_GROW2;
                    cnt_d   = REP_W'(1);
                end
                ST_GROW2: begin
                    src     = SRC_AVG;
                    len_idx = LVL_W'(1);
                    if (cnt_q == REP2 - 1) begin
                        state_d = ST_GROW4;
                        cnt_d   = '0;
                    end else cnt_d = cnt_q + 1'b1;
                end
                ST_GROW4: begin
                    src     = SRC_AVG;
                    len_idx = LVL_W'(2);
                    if (cnt_q == REP4 - 1) begin
                        state_d = ST_GROW8;
                        cnt_d   = '0;
                    end else cnt_d = cnt_q + 1'b1;
                end
                ST_GROW8: begin
                    src     = SRC_AVG;
                    len_idx = LVL_W'(3);
                    if (cnt_q == REP8 - 1) begin
                        state_d = ST_GROW16;
                        cnt_d   = '0;
                    end else cnt_d = cnt_q + 1'b1;
                end
                ST_GROW16: begin
                    src     = SRC_AVG;
                    len_idx = LVL_W'(4);
                    if (cnt_q == REP16 - 1) begin
                        state_d = ST_FIR_PASS;
                        cnt_d   = '0;
                    end else cnt_d = cnt_q + 1'b1;
                end
                default: begin
                    state_d = ST_FIR_PASS;
                    cnt_d   = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/step_avg_filter.sv
module step_avg_filter #(
    parameter int W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic signed [W-1:0] smp_data,
    input  logic signed [W-1:0] fir_data,
    input  logic                fast_en,
    input  logic                skip_en,
    input  logic                chop_en,
    input  logic [W-1:0]        full_scale,
    output logic                out_valid,
    output logic signed [W-1:0] out_data,
    output logic                out_transient,
    output logic                out_pair_tag
);
    import sfa_pkg::*;

    logic [AVG_LVLS-1:0][W-1:0] avg_w;
    logic signed [W-1:0]        prev2_w;
    logic                       step_w;
    sfa_src_e                   src_w;
    logic [LVL_W-1:0]           len_idx_w;
    sfa_state_e                 fsm_state;
    logic                       phase_q;
    logic                       pair_mode;
    logic signed [W-1:0]        sel_data;

    sfa_history #(.W(W)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (smp_valid),
        .din     (smp_data),
        .avg_o   (avg_w),
        .prev2_o (prev2_w)
    );

    sfa_step_det #(.W(W)) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (smp_valid),
        .din        (smp_data),
        .prev2      (prev2_w),
        .full_scale (full_scale),
        .step       (step_w)
    );

    sfa_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (smp_valid),
        .fast_en (fast_en),
        .skip_en (skip_en),
        .chop_en (chop_en),
        .step    (step_w),
        .src     (src_w),
        .len_idx (len_idx_w),
        .state_o (fsm_state)
    );

    assign pair_mode = skip_en && chop_en;

    always_comb begin
        unique case (src_w)
            SRC_AVG: sel_data = avg_w[len_idx_w];
            SRC_RAW: sel_data = smp_data;
            default: sel_data = fir_data;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_data      <= '0;
            out_transient <= 1'b0;
            out_pair_tag  <= 1'b0;
            phase_q       <= 1'b0;
        end else begin
            out_valid <= smp_valid;
            if (smp_valid) begin
                out_data      <= sel_data;
                out_transient <= (src_w == SRC_AVG);
                out_pair_tag  <= pair_mode ? phase_q : 1'b0;
                phase_q       <= pair_mode ? ~phase_q : 1'b0;
            end
        end
    end
endmodule

// File: rtl/step_avg_filter_chk.sv
module step_avg_filter_chk #(
    parameter int W = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_valid,
    input logic signed [W-1:0] smp_data,
    input logic signed [W-1:0] fir_data,
    input logic                fast_en,
    input logic                skip_en,
    input logic                chop_en,
    input logic                out_valid,
    input logic signed [W-1:0] out_data,
    input logic                out_transient,
    input logic                out_pair_tag,
    input sfa_pkg::sfa_state_e fsm_state
);
    import sfa_pkg::*;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid);

    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !out_valid);

    // R8
    skip_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && skip_en) |=> (out_data == $past(smp_data) && !out_transient));

    // R7
    fast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !skip_en && !fast_en) |=> (out_data == $past(fir_data) && !out_transient));

    // R9
    pair_tag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !(skip_en && chop_en)) |=> !out_pair_tag);

    // R6
    avg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && fast_en && !skip_en && fsm_state != ST_FIR_PASS) |=> out_transient);
endmodule

bind step_avg_filter step_avg_filter_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .smp_valid     (smp_valid),
    .smp_data      (smp_data),
    .fir_data      (fir_data),
    .fast_en       (fast_en),
    .skip_en       (skip_en),
    .chop_en       (chop_en),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .out_transient (out_transient),
    .out_pair_tag  (out_pair_tag),
    .fsm_state     (fsm_state)
);

// File: tb/step_avg_filter_tb.sv
module step_avg_filter_tb;
    localparam int W = 24;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                smp_valid;
    logic signed [W-1:0] smp_data;
    logic signed [W-1:0] fir_data;
    logic                fast_en, skip_en, chop_en;
    logic [W-1:0]        full_scale;
    logic                out_valid;
    logic signed [W-1:0] out_data;
    logic                out_transient, out_pair_tag;

    always #2 clk = ~clk;

    step_avg_filter #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .fir_data(fir_data), .fast_en(fast_en), .skip_en(skip_en), .chop_en(chop_en),
        .full_scale(full_scale), .out_valid(out_valid), .out_data(out_data),
        .out_transient(out_transient), .out_pair_tag(out_pair_tag)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    longint mh [15];
    int     mfill, mstate, mcnt;
    bit     mph;
    longint last_d;
    bit     last_t, last_g;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic longint mavg(input longint x, input int n);
        longint s = x;
        int sh = 0;
        for (int k = 0; k < n-1; k++) s += mh[k];
        while ((1 << sh) < n) sh++;
        return s >>> sh;
    endfunction

    task automatic model(input longint x, input longint f, output longint ed,
                         output bit et, output bit eg, output string req);
        longint thr = longint'(full_scale) / 100;
        longint d   = x - mh[1];
        bit step;
        if (d < 0) d = -d;
        step = (mfill >= 2) && (d > thr);
        et = 0;
        if (skip_en) begin
            ed = x; req = "R8"; mstate = 0; mcnt = 0;
        end else if (!fast_en) begin
            ed = f; req = "R7"; mstate = 0; mcnt = 0;
        end else if (step) begin
            req = (mstate >= 2) ? "R5" : "R3";
            ed = mavg(x, chop_en ? 2 : 1); et = 1; mstate = 1; mcnt = 0;
        end else begin
            case (mstate)
                0: begin ed = f; req = "R2"; end
                1: begin ed = mavg(x, 2); et = 1; req = "R4/R10"; mstate = 2; mcnt = 1; end
                2: begin ed = mavg(x, 2); et = 1; req = "R4/R10";
                         if (mcnt == 1) begin mstate = 3; mcnt = 0; end else mcnt++; end
                3: begin ed = mavg(x, 4); et = 1; req = "R4/R10";
                         if (mcnt == 3) begin mstate = 4; mcnt = 0; end else mcnt++; end
                4: begin ed = mavg(x, 8); et = 1; req = "R4/R10";
                         if (mcnt == 7) begin mstate = 5; mcnt = 0; end else mcnt++; end
                default: begin ed = mavg(x, 16); et = 1; req = "R4/R10";
                         if (mcnt == 5) begin mstate = 0; mcnt = 0; end else mcnt++; end
            endcase
        end
        if (skip_en && chop_en) begin eg = mph; mph = !mph; end
        else begin eg = 0; mph = 0; end
        for (int k = 14; k > 0; k--) mh[k] = mh[k-1];
        mh[0] = x;
        if (mfill < 2) mfill++;
    endtask

    task automatic push(input longint x, input longint f);
        longint ed; bit et, eg; string req;
        smp_valid = 1'b1;
        smp_data  = W'(x);
        fir_data  = W'(f);
        model(x, f, ed, et, eg, req);
        @(negedge clk);
        chk("R1 valid", longint'(out_valid), 1);
        chk(req, longint'(out_data), ed);
        chk("R6 flag", longint'(out_transient), longint'(et));
        chk("R9 tag", longint'(out_pair_tag), longint'(eg));
        last_d = ed; last_t = et; last_g = eg;
    endtask

    task automatic idle(input int n);
        smp_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R1 idle", longint'(out_valid), 0);
            chk("R1 hold", longint'(out_data), last_d);
        end
    endtask

    function automatic longint noise(input int amp);
        return longint'($urandom_range(2*amp, 0)) - amp;
    endfunction

    task automatic run_step(input longint lo, input longint hi, input int settle);
        for (int i = 0; i < 6; i++) push(lo + noise(300), noise(5000));
        for (int i = 0; i < 3; i++) push(hi + noise(300), noise(5000));
        for (int i = 0; i < settle; i++) push(hi + noise(300), noise(5000));
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < 15; k++) mh[k] = 0;
        mfill = 0; mstate = 0; mcnt = 0; mph = 0; last_d = 0;
        rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; fir_data = '0;
        fast_en = 1'b1; skip_en = 1'b0; chop_en = 1'b1; full_scale = 24'd1000000;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 valid", longint'(out_valid), 0);
        chk("R11 data", longint'(out_data), 0);
        chk("R11 flag", longint'(out_transient), 0);
        chk("R11 tag", longint'(out_pair_tag), 0);
        rst_n = 1'b1;
        idle(3);

        // R3 R4: chop step with full schedule
        run_step(1000, 300000, 26);
        // R3 chop off, falling step
        chop_en = 1'b0;
        run_step(300000, -200000, 26);
        // R5 restart mid-schedule
        chop_en = 1'b1;
        run_step(-200000, 50000, 8);
        run_step(50000, 400000, 26);
        // R7 fast off
        fast_en = 1'b0;
        run_step(400000, 0, 4);
        // R8 R9 skip with chop, gap in between
        fast_en = 1'b1; skip_en = 1'b1;
        for (int i = 0; i < 5; i++) push(noise(800000), noise(9000));
        idle(2);
        for (int i = 0; i < 4; i++) push(noise(800000), noise(9000));
        chop_en = 1'b0;
        for (int i = 0; i < 3; i++) push(noise(800000), noise(9000));
        skip_en = 1'b0; chop_en = 1'b1;
        for (int i = 0; i < 30; i++) push(noise(100), noise(9000));
        // R2 threshold boundary: difference equal to threshold is no step
        full_scale = 24'd2000000; idle(2);
        push(0, 11); push(0, 12); push(20000, 13); push(20000, 14);
        push(40001, 15); push(40001, 16);
        for (int i = 0; i < 24; i++) push(40001, 17 + i);

        // random mix
        for (int it = 0; it < 700; it++) begin
            longint lvl;
            if ($urandom_range(40, 0) == 0) begin
                full_scale = W'($urandom_range(8000000, 100000)); idle(2);
            end
            if ($urandom_range(30, 0) == 0) fast_en = ~fast_en;
            if ($urandom_range(40, 0) == 0) skip_en = ~skip_en;
            if ($urandom_range(25, 0) == 0) chop_en = ~chop_en;
            lvl = ($urandom_range(15, 0) == 0) ? noise(3000000) : mh[0];
            push(lvl + noise(600), noise(3000000));
            if ($urandom_range(8, 0) == 0) idle(1);
        end
        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule